// File: doc/BRIEF.md
# Dual-Output Compare-Match PWM Timer

This block is one timer channel that produces two pulse-width-modulated outputs, A and B, from a single shared up-counter. The counter wraps at a shared period value, so both outputs always run at the same period. Each output has its own duty compare value. Each output also has three programmable actions, one for each event: a match on its own compare value, a match on the period value, and a software trigger. Each action leaves the output alone, sets it or clears it. The waveform polarity comes from how the actions are programmed, not from a comparator inversion.

Software programs the block through a simple write port. It sets the compare values, the action fields and the counting clock source, then writes a command word. A command with the trigger bit restarts the counter and forces each output to its trigger level. The enable and disable bits in the same word start or stop counting. The clock source is one of four power-of-two taps of the block clock or an external slow-tick strobe.

When no compare actions are armed (duty of zero or duty equal to the period), an output holds the level its trigger action gave it.

Top module: `cmpwm_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both outputs are low, counting is stopped and every action is none.
- R2: Register address 1 holds the clock select in `wr_data[2:0]`. Values 0 to 3 pick a tap that fires when the low 2k+1 bits of a free-running cycle counter (cleared by reset) are all ones, which divides the clock by 2, 8, 32 or 128. Value 4 picks `slow_tick`. Values 5 to 7 give no ticks. The counter changes only on a selected tick while counting is enabled, or on a trigger.
- R3: On a tick where the counter equals the period value (address 6), the counter returns to 0. On any other tick it adds one, wrapping at 2^CNT_W. The period is therefore the period value + 1 ticks.
- R4: The action word for A is at address 2 and for B at address 3. Bits [1:0] are the own-compare action, bits [3:2] the period action and bits [5:4] the trigger action. Code 1 sets, code 2 clears, and 0 or 3 does nothing. On a tick where the counter equals the output's compare value (A: address 4, B: address 5), the own-compare action is applied.
- R5: When the own compare and the period value both match on one tick and the period action is set or clear, the period action wins.
- R6: A command write (address 0) with bit 0 set loads the counter with 0 and applies each output's trigger action on the same edge. Any tick on that edge is ignored.
- R7: In the command word, bit 1 enables counting and bit 2 disables it, with disable winning. While counting is disabled, the outputs change only through a trigger.
- R8: With own = clear, period = set and trigger = set, the output is high for compare + 1 ticks of every period value + 1 ticks. With own = set, period = clear and trigger = clear, it is high for the remaining period value − compare ticks.
- R9: With both compare actions none, an output stays at the level its trigger action applied, whatever the counter does.
- R10: A write changes its register on the edge that samples it, and takes part in events from the next edge on. Writes to address 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| slow_tick | input | 1 | One-cycle strobe of the slow clock source |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
Every result of this block is registered once. The counter, both output levels and every register change on the same edge that samples the tick, the trigger write or the register write, so each effect is visible one cycle after its stimulus is applied. The bench drives inputs on the falling edge and samples outputs 1 ns after the following rising edge. Right before each sample, it steps its own model with the inputs of that cycle, so each comparison lines up with the edge the result depends on. Multi-cycle properties such as duty ratio are measured over whole periods, counted from ticks whose timing the bench controls through `slow_tick`.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;

    localparam int ADDR_W   = 3;
    localparam int SEL_W    = 3;
    localparam int NUM_CH   = 2;

    localparam logic [ADDR_W-1:0] ADR_CMD   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_SEL   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_ACT_A = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_ACT_B = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CMP_A = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CMP_B = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_PER   = 3'd6;

    localparam int CMD_TRIG = 0;
    localparam int CMD_EN   = 1;
    localparam int CMD_DIS  = 2;

    localparam int ACT_BITS = 6;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } act_e;

    // packed layout: trg = [5:4], per = [3:2], own = [1:0]
    typedef struct packed {
        act_e trg;
        act_e per;
        act_e own;
    } out_act_t;

    function automatic logic act_live(input act_e a);
        return (a == ACT_SET) || (a == ACT_CLR);
    endfunction

    function automatic logic act_apply(input act_e a, input logic cur);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/cmpwm_tickgen.sv
module cmpwm_tickgen
    import cmpwm_pkg::*;
#(
    parameter int NUM_TAPS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             slow_tick,
    output logic             tick
);
    localparam int PW = 2 * NUM_TAPS - 1;

    logic [PW-1:0]       presc;
    logic [NUM_TAPS-1:0] tap_hit;

    always_ff @(posedge clk) begin
        if (rst) presc <= '0;
        else     presc <= presc + 1'b1;
    end

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign tap_hit[k] = &presc[2*k:0];
    end

    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (sel == SEL_W'(k)) tick = tap_hit[k];
        end
        if (sel == SEL_W'(NUM_TAPS)) tick = slow_tick;
    end

endmodule

// File: rtl/cmpwm_counter.sv
module cmpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             restart,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (restart) cnt <= '0;
        else if (tick_en) cnt <= (cnt == per) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/cmpwm_outch.sv
module cmpwm_outch
    import cmpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             restart,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] per,
    input  out_act_t         act,
    output logic             lvl
);
    logic per_hit;
    logic own_hit;

    assign per_hit = (cnt == per);
    assign own_hit = (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
        end else if (restart) begin
            lvl <= act_apply(act.trg, lvl);
        end else if (tick_en) begin
            if (per_hit && act_live(act.per)) lvl <= act_apply(act.per, lvl);
            else if (own_hit)                 lvl <= act_apply(act.own, lvl);
        end
    end
endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer
    import cmpwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_TAPS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              slow_tick,
    output logic              pwm_a,
    output logic              pwm_b
);
    logic [SEL_W-1:0] sel_q;
    out_act_t         act_q [NUM_CH];
    logic [CNT_W-1:0] cmp_q [NUM_CH];
    logic [CNT_W-1:0] per_q;
    logic             clk_on;
    logic             cmd_wr;
    logic             trig_w;
    logic             tick_raw;
    logic             tick_en;
    logic [CNT_W-1:0] cnt;
    logic [NUM_CH-1:0] lvl;

    assign cmd_wr  = wr_en && (wr_addr == ADR_CMD);
    assign trig_w  = cmd_wr && wr_data[CMD_TRIG];
    assign tick_en = tick_raw && clk_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            per_q  <= '0;
            clk_on <= 1'b0;
            for (int i = 0; i < NUM_CH; i++) begin
                act_q[i] <= '{trg: ACT_NONE, per: ACT_NONE, own: ACT_NONE};
                cmp_q[i] <= '0;
            end
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CMD: begin
                    if (wr_data[CMD_DIS])     clk_on <= 1'b0;
                    else if (wr_data[CMD_EN]) clk_on <= 1'b1;
                end
                ADR_SEL:   sel_q    <= wr_data[SEL_W-1:0];
                ADR_ACT_A: act_q[0] <= out_act_t'(wr_data[ACT_BITS-1:0]);
                ADR_ACT_B: act_q[1] <= out_act_t'(wr_data[ACT_BITS-1:0]);
                ADR_CMP_A: cmp_q[0] <= wr_data;
                ADR_CMP_B: cmp_q[1] <= wr_data;
                ADR_PER:   per_q    <= wr_data;
                default: ;
            endcase
        end
    end

    cmpwm_tickgen #(.NUM_TAPS(NUM_TAPS)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel_q),
        .slow_tick (slow_tick),
        .tick      (tick_raw)
    );

    cmpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .restart (trig_w),
        .per     (per_q),
        .cnt     (cnt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cmpwm_outch #(.CNT_W(CNT_W)) u_out (
            .clk     (clk),
            .rst     (rst),
            .tick_en (tick_en),
            .restart (trig_w),
            .cnt     (cnt),
            .cmp     (cmp_q[c]),
            .per     (per_q),
            .act     (act_q[c]),
            .lvl     (lvl[c])
        );
    end

    assign pwm_a = lvl[0];
    assign pwm_b = lvl[1];

endmodule

// File: rtl/cmpwm_checker.sv
module cmpwm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             restart,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per,
    input logic [1:0]       per_act_a,
    input logic             clk_on,
    input logic             cmd_wr,
    input logic [1:0]       cmd_en_dis,
    input logic             pwm_a,
    input logic             pwm_b
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!pwm_a && !pwm_b && !clk_on));

    a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !restart) |=> $stable(cnt));

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !restart && cnt == per) |=> (cnt == '0));

    a_r5_period_wins: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !restart && cnt == per && per_act_a == 2'd1) |=> pwm_a);

    a_r6_trigger_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    a_r7_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (!clk_on && !restart) |=> ($stable(pwm_a) && $stable(pwm_b)));

    a_r7_enable_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_en_dis == 2'b01) |=> clk_on);

    a_r7_disable_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_en_dis[1]) |=> !clk_on);
endmodule

bind cmpwm_timer cmpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .restart    (trig_w),
    .cnt        (cnt),
    .per        (per_q),
    .per_act_a  (act_q[0].per),
    .clk_on     (clk_on),
    .cmd_wr     (cmd_wr),
    .cmd_en_dis (wr_data[2:1]),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b)
);

// File: tb/test_cmpwm_timer.sv
module test_cmpwm_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [2:0]   wr_addr;
    logic [W-1:0] wr_data;
    logic         slow_tick;
    logic         pwm_a;
    logic         pwm_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    string tag = "R1";

    // model state
    logic [6:0]   m_presc;
    logic [2:0]   m_sel;
    logic [5:0]   m_act [2];
    logic [W-1:0] m_cmp [2];
    logic [W-1:0] m_per;
    logic         m_on;
    logic [W-1:0] m_cnt;
    logic         m_out [2];

    always #2 clk = ~clk;

    cmpwm_timer #(.CNT_W(W)) i_cmpwm_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slow_tick(slow_tick), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic logic f_apply(input logic [1:0] code, input logic cur);
        if (code == 2'd1) return 1'b1;
        if (code == 2'd2) return 1'b0;
        return cur;
    endfunction

    function automatic logic f_tick(input logic [2:0] sel, input logic [6:0] p,
                                    input logic sl);
        if (sel < 3'd4) begin
            logic [6:0] mask;
            mask = 7'((2 << (2 * sel)) - 1);
            return (p & mask) == mask;
        end
        if (sel == 3'd4) return sl;
        return 1'b0;
    endfunction

    task automatic chk(input logic act, input logic exp, input string t, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", t, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic r, input logic we, input logic [2:0] a,
                              input logic [W-1:0] d, input logic sl);
        logic tk;
        logic trig;
        if (r) begin
            m_presc = '0; m_sel = '0; m_per = '0; m_on = 0; m_cnt = '0;
            for (int i = 0; i < 2; i++) begin
                m_act[i] = '0; m_cmp[i] = '0; m_out[i] = 0;
            end
            return;
        end
        tk   = m_on && f_tick(m_sel, m_presc, sl);
        trig = we && a == 3'd0 && d[0];
        if (trig) begin
            m_cnt = '0;
            for (int i = 0; i < 2; i++) m_out[i] = f_apply(m_act[i][5:4], m_out[i]);
        end else if (tk) begin
            for (int i = 0; i < 2; i++) begin
                if (m_cnt == m_per && (m_act[i][3:2] == 2'd1 || m_act[i][3:2] == 2'd2))
                    m_out[i] = f_apply(m_act[i][3:2], m_out[i]);
                else if (m_cnt == m_cmp[i])
                    m_out[i] = f_apply(m_act[i][1:0], m_out[i]);
            end
            m_cnt = (m_cnt == m_per) ? '0 : m_cnt + 1'b1;
        end
        if (we) begin
            case (a)
                3'd0: if (d[2]) m_on = 0; else if (d[1]) m_on = 1;
                3'd1: m_sel = d[2:0];
                3'd2: m_act[0] = d[5:0];
                3'd3: m_act[1] = d[5:0];
                3'd4: m_cmp[0] = d;
                3'd5: m_cmp[1] = d;
                3'd6: m_per = d;
                default: ;
            endcase
        end
        m_presc = m_presc + 1'b1;
    endtask

    task automatic step(input logic r, input logic we, input logic [2:0] a,
                        input logic [W-1:0] d, input logic sl);
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = a; wr_data = d; slow_tick = sl;
        @(posedge clk);
        #1;
        model_step(r, we, a, d, sl);
        chk(pwm_a, m_out[0], tag, "pwm_a vs model");
        chk(pwm_b, m_out[1], tag, "pwm_b vs model");
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        step(0, 1, a, d, 1);
    endtask

    task automatic idle(input int n, input logic sl);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, '0, sl);
    endtask

    task automatic count_high(input int n, output int ca, output int cb);
        ca = 0; cb = 0;
        for (int i = 0; i < n; i++) begin
            step(0, 0, 3'd0, '0, 1);
            if (pwm_a) ca++;
            if (pwm_b) cb++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int ca;
        int cb;
        void'($urandom(32'h5eed_2024));
        rst = 1; wr_en = 0; wr_addr = '0; wr_data = '0; slow_tick = 0;

        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 4; i++) step(1, 0, 3'd0, '0, 0);
        step(0, 0, 3'd0, '0, 1);
        chk(pwm_a, 1'b0, "R1", "pwm_a after reset");
        chk(pwm_b, 1'b0, "R1", "pwm_b after reset");
        // R7: counting stopped after reset: a trigger-less tick changes nothing
        wr(3'd2, 16'h0016); wr(3'd6, 16'd2); idle(6, 1);
        chk(pwm_a, 1'b0, "R7", "pwm_a stays low while stopped");

        // R9: full duty on A (trigger set), zero duty on B (trigger clear)
        tag = "R9";
        wr(3'd1, 16'd4);
        wr(3'd2, 16'h0010);
        wr(3'd3, 16'h0020);
        wr(3'd6, 16'd5);
        wr(3'd0, 16'h0003);
        idle(20, 1);
        chk(pwm_a, 1'b1, "R9", "full duty held high");
        chk(pwm_b, 1'b0, "R9", "zero duty held low");

        // R8: normal on A, inverted on B, compare 3, period value 9
        tag = "R8";
        wr(3'd2, 16'h0016);
        wr(3'd3, 16'h0029);
        wr(3'd4, 16'd3);
        wr(3'd5, 16'd3);
        wr(3'd6, 16'd9);
        wr(3'd0, 16'h0003);
        idle(15, 1);
        count_high(10, ca, cb);
        chk(ca == 4, 1'b1, "R8", "normal high count == cmp+1");
        chk(cb == 6, 1'b1, "R8", "inverted high count == per-cmp");
        // R3: second full period gives the same counts (period = per+1 ticks)
        count_high(10, ca, cb);
        chk(ca == 4 && cb == 6, 1'b1, "R3", "counts repeat over per+1 ticks");

        // R5: compare equals period value: period action wins
        tag = "R5";
        wr(3'd4, 16'd9);
        wr(3'd0, 16'h0003);
        idle(12, 1);
        count_high(10, ca, cb);
        chk(ca == 10, 1'b1, "R5", "period set beats own clear");

        // R6: trigger restarts and applies trigger level mid-period
        tag = "R6";
        wr(3'd2, 16'h0026);
        wr(3'd0, 16'h0001);
        chk(pwm_a, 1'b0, "R6", "trigger clear applied same edge");

        // R7: disable with trigger freezes outputs; compare writes do nothing
        tag = "R7";
        wr(3'd2, 16'h0016);
        wr(3'd4, 16'd2);
        wr(3'd0, 16'h0007);
        idle(20, 1);
        chk(pwm_a, 1'b1, "R7", "frozen at trigger level");
        wr(3'd4, 16'd0);
        idle(10, 1);
        chk(pwm_a, 1'b1, "R7", "still frozen after compare write");

        // R2: tap 0 (divide by 2), then a no-tick select
        tag = "R2";
        wr(3'd1, 16'd0);
        wr(3'd4, 16'd1);
        wr(3'd6, 16'd3);
        wr(3'd0, 16'h0003);
        idle(40, 0);
        wr(3'd1, 16'd2);
        idle(100, 0);
        wr(3'd1, 16'd6);
        idle(5, 1);
        ca = int'(pwm_a);
        idle(30, 1);
        chk(pwm_a, ca[0], "R2", "no ticks on select 6");

        // R10: address 7 has no effect
        tag = "R10";
        wr(3'd1, 16'd4);
        idle(7, 1);
        wr(3'd7, 16'hffff);
        idle(12, 1);

        // R4: random programming mixed with ticks, checked against model
        tag = "R4";
        for (int i = 0; i < 6000; i++) begin
            logic [2:0]   a;
            logic [W-1:0] d;
            logic         we;
            we = ($urandom_range(0, 5) == 0);
            a  = 3'($urandom_range(0, 7));
            case (a)
                3'd0:    d = W'($urandom_range(0, 7));
                3'd1:    d = ($urandom_range(0, 3) == 0) ? W'($urandom_range(0, 7)) : W'(4);
                3'd2,
                3'd3:    d = W'($urandom_range(0, 63));
                default: d = W'($urandom_range(0, 12));
            endcase
            step(0, we, a, d, 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule